// File: doc/BRIEF.md
# Successive-Approximation Converter Control Sequencer

This block is the digital control core of a 16-bit successive-approximation converter that presents its result over an 8-bit parallel port. A host drives an active-low chip select together with a read/convert level. Successive falling edges of chip select step the block through three phases:
- acquisition, with the sample switch closed and the reference powered;
- conversion, with the sample held and a bit-by-bit search against an external comparator;
- readout, with the result placed on the byte bus, high or low half chosen by a byte-select input.

The read/convert level seen on the conversion-start edge is latched. It decides whether the reference stays powered after the conversion (standby) or is switched off (shutdown). A parameter selects the converter's range. In bipolar mode the trial codes go to the DAC in two's complement and the bus carries offset binary. In unipolar mode both use straight binary.

The analog front end, the comparator and the DAC sit outside this block. Chip select and read/convert are asynchronous to the system clock and are brought in through a two-flop synchronizer before edge detection.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, `eoc_n` is 1, `data_oe` is 0, `data_out` is 0, `track_en` is 0 and `ref_en` is 0.
- R2: In the idle phase, a chip-select falling edge with `rd_conv` low sets `ref_en` and `track_en` to 1 (acquisition). The same edge with `rd_conv` high is ignored: `track_en` and `ref_en` stay 0.
- R3: The next chip-select falling edge clears `track_en` and starts conversion. `eoc_n` goes low no later than `CONV_MAX_CYC` (587) clock cycles after that edge.
- R4: The result is found MSB first, one bit per clock. A trial bit is kept when `cmp_keep` is 1, meaning the DAC output is at or below the held input. The 16-bit result is the largest code whose DAC level does not exceed the held input.
- R5: The `rd_conv` level on the conversion-start edge is latched. If it was 1, `ref_en` drops to 0 when `eoc_n` falls (shutdown). If it was 0, `ref_en` stays 1 (standby).
- R6: With `eoc_n` low, a chip-select falling edge with `rd_conv` high sets `data_oe` to 1. The same edge with `rd_conv` low is ignored: `data_oe` stays 0 and `eoc_n` stays 0.
- R7: While `data_oe` is 1, `hi_byte_sel`=1 puts result bits 15..8 on `data_out`, and `hi_byte_sel`=0 puts bits 7..0.
- R8: `data_oe` is 0 and `data_out` is 0 throughout acquisition and conversion.
- R9: A chip-select rise during readout returns `data_oe` and `data_out` to 0 and `eoc_n` to 1, and the block waits in idle.
- R10: With `BIPOLAR`=1, the first trial code on `dac_code` is 16'h0000 (two's complement midscale) and the bus carries offset binary, which equals the signed input with bit 15 inverted. With `BIPOLAR`=0, the first trial is 16'h8000 and the bus carries straight binary equal to the input.
- R11: Chip-select edges that arrive during conversion, whatever the `rd_conv` level, change neither the result nor the latched power mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| rd_conv | input | 1 | Read/convert qualifier, asynchronous |
| hi_byte_sel | input | 1 | 1 selects result bits 15..8, 0 selects bits 7..0 |
| cmp_keep | input | 1 | Comparator: 1 when DAC level is at or below the held input |
| eoc_n | output | 1 | End of conversion, low when the result is ready |
| data_out | output | 8 | Result byte, 0 when not enabled |
| data_oe | output | 1 | Bus drive enable |
| track_en | output | 1 | Sample switch closed (acquisition) |
| ref_en | output | 1 | Reference and buffer power enable |
| dac_code | output | 16 | Trial code for the DAC |

## Verification
The case hardest to reach from the ports is a chip-select edge that lands while the bit search is still running. It is the only point where the sequencer could let a stray edge disturb the search or the latched power mode. The bench reaches it by releasing chip select right after the conversion-start edge and pulsing it again with the opposite `rd_conv` level. Each pulse lasts only a few cycles, short enough that it ends before the 16-step search completes. The bench also sends a low-qualified edge between the end of conversion and the read. Two instances, one bipolar and one unipolar, are swept across extreme and scattered input codes.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ACQ  = 3'd1,
    PH_CONV = 3'd2,
    PH_DONE = 3'd3,
    PH_READ = 3'd4
  } phase_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int RES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           keep,
  output logic [RES-1:0] code,
  output logic           busy,
  output logic           done
);
  localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] code_q, code_d;
  logic [RES-1:0] mask_q, mask_d;
  logic           busy_q, busy_d;
  logic           done_q, done_d;

  always_comb begin
    code_d = code_q;
    mask_d = mask_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      code_d = TOP_BIT;
      mask_d = TOP_BIT;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (!keep) code_d = code_q & ~mask_q;
      if (mask_q[0]) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        code_d = code_d | (mask_q >> 1);
        mask_d = mask_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      code_q <= code_d;
      mask_q <= mask_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign code = code_q;
  assign busy = busy_q;
  assign done = done_q;

  AST_SEARCH_SEED: assert property (@(posedge clk) disable iff (!rst_n) start |=> (code_q == TOP_BIT)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R3
  AST_SINGLE_TRIAL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mask_q)); // R4
  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!busy_q && !start) |=> $stable(code_q)); // R11
endmodule

// File: rtl/sar_out_fmt.sv
module sar_out_fmt #(
  parameter int RES     = 16,
  parameter bit BIPOLAR = 1'b1
) (
  input  logic [RES-1:0]   trial,
  input  logic             hben,
  input  logic             oe,
  output logic [RES-1:0]   dac_code,
  output logic [RES/2-1:0] data_out
);
  localparam int BW = RES / 2;

  generate
    if (BIPOLAR) begin : g_twos
      assign dac_code = {~trial[RES-1], trial[RES-2:0]};
    end else begin : g_straight
      assign dac_code = trial;
    end
  endgenerate

  always_comb begin
    data_out = '0;
    if (oe) data_out = hben ? trial[RES-1:BW] : trial[BW-1:0];
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int RES          = 16,
  parameter bit BIPOLAR      = 1'b1,
  parameter int SYNC_STAGES  = 2,
  parameter int CONV_MAX_CYC = 587
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_conv,
  input  logic             hi_byte_sel,
  input  logic             cmp_keep,
  output logic             eoc_n,
  output logic [RES/2-1:0] data_out,
  output logic             data_oe,
  output logic             track_en,
  output logic             ref_en,
  output logic [RES-1:0]   dac_code
);
  import sar_seq_pkg::*;

  localparam int CNT_W = $clog2(CONV_MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CONV_MAX_CYC);

  logic [1:0] sync_q;
  logic       cs_s, rc_s;
  logic       cs_prev_q;
  logic       cs_fall, cs_rise;

  sar_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rd_conv, cs_n}),
    .q     (sync_q)
  );

  assign cs_s    = sync_q[0];
  assign rc_s    = sync_q[1];
  assign cs_fall = cs_prev_q & ~cs_s;
  assign cs_rise = ~cs_prev_q & cs_s;

  phase_e           phase_q, phase_d;
  logic             track_q, track_d;
  logic             ref_q, ref_d;
  logic             shut_q, shut_d;
  logic             eoc_q, eoc_d;
  logic             oe_q, oe_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             srch_start, srch_busy, srch_done;
  logic [RES-1:0]   trial;

  assign srch_start = (phase_q == PH_ACQ) && cs_fall;

  sar_search #(.RES(RES)) u_search (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srch_start),
    .keep  (cmp_keep),
    .code  (trial),
    .busy  (srch_busy),
    .done  (srch_done)
  );

  sar_out_fmt #(.RES(RES), .BIPOLAR(BIPOLAR)) u_fmt (
    .trial    (trial),
    .hben     (hi_byte_sel),
    .oe       (oe_q),
    .dac_code (dac_code),
    .data_out (data_out)
  );

  always_comb begin
    phase_d = phase_q;
    track_d = track_q;
    ref_d   = ref_q;
    shut_d  = shut_q;
    eoc_d   = eoc_q;
    oe_d    = oe_q;
    case (phase_q)
      PH_IDLE: if (cs_fall && !rc_s) begin
        phase_d = PH_ACQ;
        track_d = 1'b1;
        ref_d   = 1'b1;
      end
      PH_ACQ: if (cs_fall) begin
        phase_d = PH_CONV;
        track_d = 1'b0;
        shut_d  = rc_s;
      end
      PH_CONV: if (srch_done) begin
        phase_d = PH_DONE;
        eoc_d   = 1'b0;
        if (shut_q) ref_d = 1'b0;
      end
      PH_DONE: if (cs_fall && rc_s) begin
        phase_d = PH_READ;
        oe_d    = 1'b1;
      end
      PH_READ: if (cs_rise) begin
        phase_d = PH_IDLE;
        oe_d    = 1'b0;
        eoc_d   = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    cnt_d = '0;
    if (phase_q == PH_CONV) cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      track_q   <= 1'b0;
      ref_q     <= 1'b0;
      shut_q    <= 1'b0;
      eoc_q     <= 1'b1;
      oe_q      <= 1'b0;
      cnt_q     <= '0;
      cs_prev_q <= 1'b1;
    end else begin
      phase_q   <= phase_d;
      track_q   <= track_d;
      ref_q     <= ref_d;
      shut_q    <= shut_d;
      eoc_q     <= eoc_d;
      oe_q      <= oe_d;
      cnt_q     <= cnt_d;
      cs_prev_q <= cs_s;
    end
  end

  assign eoc_n    = eoc_q;
  assign data_oe  = oe_q;
  assign track_en = track_q;
  assign ref_en   = ref_q;

  AST_REF_DURING_TRACK: assert property (@(posedge clk) disable iff (!rst_n) track_q |-> ref_q); // R2
  AST_CONV_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_CONV) |-> (cnt_q < CNT_MAX)); // R3
  AST_OE_NEEDS_EOC: assert property (@(posedge clk) disable iff (!rst_n) oe_q |-> !eoc_q); // R6
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (track_q || srch_busy) |-> (!oe_q && data_out == '0)); // R8
  AST_EOC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(eoc_q) |-> $past(cs_rise)); // R9
endmodule

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic rc = 1'b0;
  logic hben = 1'b0;
  logic [15:0] word = 16'h0000;

  logic        eoc0, eoc1, oe0, oe1, trk0, trk1, ref0, ref1, keep0, keep1;
  logic [7:0]  d0, d1;
  logic [15:0] dac0, dac1;
  logic signed [15:0] held0 = 16'sd0;
  logic [15:0] held1 = 16'h0000;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (trk0) held0 <= $signed(word);
    if (trk1) held1 <= word;
  end
  assign keep0 = ($signed(dac0) <= held0);
  assign keep1 = (dac1 <= held1);

  sar_seq_ctrl #(.BIPOLAR(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rc), .hi_byte_sel(hben),
    .cmp_keep(keep0), .eoc_n(eoc0), .data_out(d0), .data_oe(oe0),
    .track_en(trk0), .ref_en(ref0), .dac_code(dac0)
  );

  sar_seq_ctrl #(.BIPOLAR(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rc), .hi_byte_sel(hben),
    .cmp_keep(keep1), .eoc_n(eoc1), .data_out(d1), .data_oe(oe1),
    .track_en(trk1), .ref_en(ref1), .dac_code(dac1)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_drop(input logic r, input int n);
    @(negedge clk);
    rc = r;
    cs_n = 1'b0;
    ticks(n);
  endtask

  task automatic cs_raise(input int n);
    @(negedge clk);
    cs_n = 1'b1;
    ticks(n);
  endtask

  task automatic convert(input logic [15:0] w, input logic shut, input bit glitch, input bit stray);
    int t0;
    int n;
    logic [15:0] exp0;
    logic [15:0] exp1;
    exp0 = w ^ 16'h8000;
    exp1 = w;
    word = w;
    // R2 acquisition on first qualified edge
    cs_drop(1'b0, 5);
    chk(trk0 && trk1 && ref0 && ref1, "R2", {trk0, ref0}, 2'b11);
    chk(!oe0 && !oe1 && d0 == 8'h00, "R8", oe0, 0);
    cs_raise(4);
    // conversion start
    @(negedge clk);
    rc = shut;
    cs_n = 1'b0;
    t0 = cyc;
    n = 0;
    while (trk0 && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(dac0 == 16'h0000 && dac1 == 16'h8000, "R10", {dac0, dac1}, 32'h0000_8000);
    chk(!oe0 && !oe1, "R8", oe0, 0);
    ticks(2);
    cs_raise(3);
    if (glitch) begin
      // R11 stray edge of opposite qualifier during the search
      cs_drop(!shut, 3);
      cs_raise(1);
    end
    while ((eoc0 || eoc1) && (cyc - t0) < 700) @(negedge clk);
    chk((cyc - t0) <= 587, "R3", cyc - t0, 587);
    chk(ref0 == !shut && ref1 == !shut, glitch ? "R11" : "R5", ref0, !shut);
    chk(!oe0 && !oe1, "R8", oe0, 0);
    if (stray) begin
      cs_drop(1'b0, 5);
      chk(!oe0 && !oe1 && !eoc0 && !eoc1, "R6", {oe0, eoc0}, 0);
      cs_raise(4);
    end
    // readout
    cs_drop(1'b1, 5);
    chk(oe0 && oe1, "R6", {oe0, oe1}, 2'b11);
    hben = 1'b1;
    #1;
    chk(d0 == exp0[15:8], "R7", d0, exp0[15:8]);
    chk(d1 == exp1[15:8], "R10", d1, exp1[15:8]);
    hben = 1'b0;
    #1;
    chk(d0 == exp0[7:0], glitch ? "R11" : "R4", d0, exp0[7:0]);
    chk(d1 == exp1[7:0], "R4", d1, exp1[7:0]);
    cs_raise(5);
    chk(eoc0 && eoc1 && !oe0 && !oe1 && d0 == 8'h00, "R9", {eoc0, oe0}, 2'b10);
    rc = 1'b0;
  endtask

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(4);
    chk(eoc0 && eoc1 && !oe0 && !trk0 && !ref0 && d0 == 8'h00, "R1", {eoc0, oe0, trk0, ref0}, 4'b1000);
    // R2 edge with qualifier high is ignored in idle
    cs_drop(1'b1, 5);
    chk(!trk0 && !ref0 && !trk1 && !ref1, "R2", {trk0, ref0}, 0);
    cs_raise(4);
    convert(16'h0000, 1'b0, 1'b0, 1'b1);
    convert(16'hFFFF, 1'b1, 1'b1, 1'b0);
    convert(16'h0001, 1'b0, 1'b1, 1'b0);
    convert(16'h7FFF, 1'b1, 1'b0, 1'b1);
    convert(16'h8000, 1'b0, 1'b0, 1'b0);
    convert(16'hFFFE, 1'b1, 1'b0, 1'b0);
    convert(16'h8001, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k <= 150; k++) begin
      logic [15:0] w;
      w = 16'(k * 40503) ^ 16'(k << 3);
      convert(w, k[0], (k % 5) == 0, (k % 7) == 0);
    end
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!fin) begin
      nchk++;
      nerr++;
      $display("FAIL R3 watchdog expired act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule